// File: doc/BRIEF.md
# Saturating Iterative Integer Divider

This block divides one 32-bit operand by another, either as two's-complement numbers or as unsigned numbers. A one-cycle start strobe presents the operation code and both operands. The block returns the quotient and the remainder together as one 64-bit word and pulses a done strobe when the word is valid. The quotient sits in the lower half of that word and the remainder in the upper half.

Ordinary divisions use a radix-2 restoring loop. The loop works on the operand magnitudes for one step per bit. A separate cycle then applies the signs. Two cases do not trap and do not iterate. Division by zero, and signed division of the most negative value by minus one, both return a saturated quotient with a zero remainder on the cycle after the start. Each completed operation also updates three flags. The overflow flag shows whether the last operation saturated. The sticky flag collects every overflow since reset. The advance-overflow flag is cleared on every completion.

Top module: `sat_divider`

## Requirements
- R1: A completed result places the quotient in bits 31:0 and the remainder in bits 63:32. The result holds until the next completion, and doneO is high for exactly one cycle for each completed operation.
- R2: In unsigned mode with a non-zero divisor, the quotient is floor(dividend/divisor), the remainder is dividend mod divisor, and the overflow flag is cleared.
- R3: In signed mode, apart from the two saturating cases, the quotient is truncated toward zero, the remainder has the sign of the dividend (or is zero), and the overflow flag is cleared.
- R4: In signed mode with a zero divisor, the quotient is 0x7FFFFFFF when the dividend is non-negative and 0x80000000 when it is negative. The remainder is 0 and the overflow flag is set.
- R5: Signed division of 0x80000000 by 0xFFFFFFFF gives quotient 0x7FFFFFFF, remainder 0, and sets the overflow flag.
- R6: Unsigned division by zero gives quotient 0xFFFFFFFF, remainder 0, and sets the overflow flag.
- R7: At each completion the sticky flag becomes its old value OR the new overflow value, so only reset clears it. The advance-overflow flag reads 0 after every completion.
- R8: Operation code 0x20 on opI selects signed division and 0x21 selects unsigned division. A start with any other code is ignored: busyO stays low, no done follows, and the result and flags are unchanged.
- R9: An ordinary division raises busyO on the clock edge that samples the start. doneO follows W+1 edges after that one, which is 33 for W=32, and busyO falls on that same edge. A saturating case raises doneO on the very edge that samples the start and never raises busyO.
- R10: A start presented while busyO is high is ignored. The running operation completes with its own result, and no additional done pulse appears.
- R11: After reset, busyO, doneO, the result word and all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| startI | input | 1 | One-cycle request to begin a division |
| opI | input | 8 | Operation code: 0x20 signed, 0x21 unsigned |
| dividendI | input | 32 | Dividend, sampled with startI |
| divisorI | input | 32 | Divisor, sampled with startI |
| busyO | output | 1 | Iterative division in progress |
| doneO | output | 1 | Result and flags updated on the previous edge |
| resultO | output | 64 | Remainder in the upper half, quotient in the lower half |
| ovfO | output | 1 | Overflow of the last completed operation |
| stickyOvfO | output | 1 | Accumulated overflow since reset |
| advOvfO | output | 1 | Advance-overflow flag, cleared at every completion |

## Verification
Two things can fall in the same cycle: the completion of one division, and the acceptance of the next start. This is because the cycle in which doneO is high is already an idle cycle. The bench issues every operation as soon as the previous done is seen. This includes a saturating case that follows an iterative one, so doneO stays high for two consecutive cycles carrying two different results. Each result and each flag set is compared against a reference model in the bench. A start during the busy period is also provoked, using a division by zero that would complete immediately if it were wrongly taken, and the bench checks that it leaves no trace.

// File: rtl/sat_div_pkg.sv
package sat_div_pkg;

  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OP_DIV_SIGNED   = 8'h20;
  localparam logic [OP_W-1:0] OP_DIV_UNSIGNED = 8'h21;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divState_t;

  // strobes from control to datapath, at most one active per cycle
  typedef struct packed {
    logic loadIter;     // capture magnitudes and signs, start loop
    logic loadSpecial;  // write saturated result directly
    logic step;         // one restoring iteration
    logic finish;       // apply signs and publish result
  } divStrb_t;

endpackage

// File: rtl/sat_div_ctrl.sv
module sat_div_ctrl
  import sat_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startI,
  input  logic [OP_W-1:0] opI,
  input  logic            isSpecialI,
  output logic            modeSignedO,
  output divStrb_t        strbO,
  output logic            busyO,
  output logic            doneO
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  divState_t     stateQ;
  logic [CW-1:0] cntQ;
  logic          doneQ;
  logic          opValid;
  logic          accept;

  always_comb begin
    opValid     = (opI == OP_DIV_SIGNED) || (opI == OP_DIV_UNSIGNED);
    modeSignedO = (opI == OP_DIV_SIGNED);
    accept      = startI && opValid && (stateQ == ST_IDLE);
    strbO             = '0;
    strbO.loadSpecial = accept && isSpecialI;
    strbO.loadIter    = accept && !isSpecialI;
    strbO.step        = (stateQ == ST_RUN);
    strbO.finish      = (stateQ == ST_FIX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strbO.loadSpecial || strbO.finish;
      unique case (stateQ)
        ST_IDLE: begin
          if (strbO.loadIter) begin
            stateQ <= ST_RUN;
            cntQ   <= LAST_STEP;
          end
        end
        ST_RUN: begin
          if (cntQ == '0) stateQ <= ST_FIX;
          else            cntQ   <= cntQ - 1'b1;
        end
        ST_FIX:  stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busyO = (stateQ != ST_IDLE);
  assign doneO = doneQ;

  AST_FIX_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FIX) |=> (doneQ && stateQ == ST_IDLE)); // R9

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    busyO |-> !(strbO.loadIter || strbO.loadSpecial)); // R10

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strbO.loadIter, strbO.loadSpecial, strbO.step, strbO.finish})); // R1

  AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busyO && startI && !opValid) |=> (!busyO && !doneQ)); // R8

endmodule

// File: rtl/sat_div_dpath.sv
module sat_div_dpath
  import sat_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  divStrb_t       strbI,
  input  logic           modeSignedI,
  input  logic [W-1:0]   dividendI,
  input  logic [W-1:0]   divisorI,
  output logic           isSpecialO,
  output logic [2*W-1:0] resultO,
  output logic           ovfO,
  output logic           stickyO,
  output logic           advO
);

  localparam int MSB = W - 1;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = ~MOST_NEG;

  logic           aNeg, bNeg;
  logic           divByZero, signedOvf;
  logic [W-1:0]   aMag, bMag;
  logic [W-1:0]   satQuo;

  logic [W-1:0]   remQ, quoQ, dvsQ;
  logic           negQuoQ, negRemQ;
  logic [2*W-1:0] resultQ;
  logic           ovfQ, stickyQ, advQ;

  logic [W:0]     shifted;
  logic           fits;
  logic [W-1:0]   remNext;
  logic [W-1:0]   fixQuo, fixRem;

  // operand classification and magnitudes
  always_comb begin
    aNeg      = modeSignedI && dividendI[MSB];
    bNeg      = modeSignedI && divisorI[MSB];
    divByZero = (divisorI == '0);
    signedOvf = modeSignedI && (dividendI == MOST_NEG) && (divisorI == '1);
    isSpecialO = divByZero || signedOvf;
    aMag = aNeg ? (~dividendI + 1'b1) : dividendI;
    bMag = bNeg ? (~divisorI + 1'b1) : divisorI;
    if (!modeSignedI)   satQuo = '1;
    else if (divByZero) satQuo = dividendI[MSB] ? MOST_NEG : MOST_POS;
    else                satQuo = MOST_POS;
  end

  // one restoring step and the sign fix-up
  always_comb begin
    shifted = {remQ, quoQ[MSB]};
    fits    = (shifted >= {1'b0, dvsQ});
    remNext = fits ? (shifted[W-1:0] - dvsQ) : shifted[W-1:0];
    fixQuo  = negQuoQ ? (~quoQ + 1'b1) : quoQ;
    fixRem  = negRemQ ? (~remQ + 1'b1) : remQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ    <= '0;
      quoQ    <= '0;
      dvsQ    <= '0;
      negQuoQ <= 1'b0;
      negRemQ <= 1'b0;
    end else if (strbI.loadIter) begin
      remQ    <= '0;
      quoQ    <= aMag;
      dvsQ    <= bMag;
      negQuoQ <= aNeg ^ bNeg;
      negRemQ <= aNeg;
    end else if (strbI.step) begin
      remQ <= remNext;
      quoQ <= {quoQ[W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      ovfQ    <= 1'b0;
      stickyQ <= 1'b0;
      advQ    <= 1'b0;
    end else if (strbI.loadSpecial) begin
      resultQ <= {{W{1'b0}}, satQuo};
      ovfQ    <= 1'b1;
      stickyQ <= 1'b1;
      advQ    <= 1'b0;
    end else if (strbI.finish) begin
      resultQ <= {fixRem, fixQuo};
      ovfQ    <= 1'b0;
      advQ    <= 1'b0;
    end
  end

  assign resultO = resultQ;
  assign ovfO    = ovfQ;
  assign stickyO = stickyQ;
  assign advO    = advQ;

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strbI.step |-> (remQ < dvsQ)); // R2

  AST_SAT_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    strbI.loadSpecial |=> (ovfQ && stickyQ && resultQ[2*W-1:W] == '0)); // R4

  AST_NORMAL_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    strbI.finish |=> !ovfQ); // R3

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    stickyQ |=> stickyQ); // R7

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strbI.finish || strbI.loadSpecial) |=> $stable(resultQ)); // R1

endmodule

// File: rtl/sat_divider.sv
module sat_divider
  import sat_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startI,
  input  logic [7:0]     opI,
  input  logic [W-1:0]   dividendI,
  input  logic [W-1:0]   divisorI,
  output logic           busyO,
  output logic           doneO,
  output logic [2*W-1:0] resultO,
  output logic           ovfO,
  output logic           stickyOvfO,
  output logic           advOvfO
);

  divStrb_t strb;
  logic     modeSigned;
  logic     isSpecial;

  sat_div_ctrl #(.W(W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startI      (startI),
    .opI         (opI),
    .isSpecialI  (isSpecial),
    .modeSignedO (modeSigned),
    .strbO       (strb),
    .busyO       (busyO),
    .doneO       (doneO)
  );

  sat_div_dpath #(.W(W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strbI       (strb),
    .modeSignedI (modeSigned),
    .dividendI   (dividendI),
    .divisorI    (divisorI),
    .isSpecialO  (isSpecial),
    .resultO     (resultO),
    .ovfO        (ovfO),
    .stickyO     (stickyOvfO),
    .advO        (advOvfO)
  );

endmodule

// File: tb/sat_divider_test.sv
module sat_divider_test;

  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rstN;
  logic           startI;
  logic [7:0]     opI;
  logic [W-1:0]   dividendI, divisorI;
  logic           busyO, doneO, ovfO, stickyOvfO, advOvfO;
  logic [2*W-1:0] resultO;

  int  nChk = 0;
  int  nBad = 0;
  bit  stickyExp = 1'b0;

  always #5 clk = ~clk;

  sat_divider #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .startI(startI), .opI(opI),
    .dividendI(dividendI), .divisorI(divisorI),
    .busyO(busyO), .doneO(doneO), .resultO(resultO),
    .ovfO(ovfO), .stickyOvfO(stickyOvfO), .advOvfO(advOvfO)
  );

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic void refDiv(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                                 output logic [31:0] q, output logic [31:0] r, output bit ov);
    if (b == 32'd0) begin
      r  = 32'd0;
      ov = 1'b1;
      if (!sgn)      q = 32'hFFFF_FFFF;
      else if (a[31]) q = 32'h8000_0000;
      else           q = 32'h7FFF_FFFF;
    end else if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      q = 32'h7FFF_FFFF; r = 32'd0; ov = 1'b1;
    end else if (sgn) begin
      q = 32'($signed(a) / $signed(b));
      r = 32'($signed(a) % $signed(b));
      ov = 1'b0;
    end else begin
      q = a / b; r = a % b; ov = 1'b0;
    end
  endfunction

  // issues one operation at a falling edge and waits for its done pulse
  task automatic runOp(input bit sgn, input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] q, r;
    bit ov;
    int cyc;
    refDiv(sgn, a, b, q, r, ov);
    opI = sgn ? 8'h20 : 8'h21;
    dividendI = a;
    divisorI = b;
    startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    dividendI = $urandom;
    divisorI = $urandom;
    cyc = 1;
    if (!ov) check({tag, " busy after start R9"}, 64'(busyO), 64'd1);
    else     check({tag, " no busy for saturating case R9"}, 64'(busyO), 64'd0);
    while (!doneO && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    check({tag, " latency R9"}, 64'(cyc), ov ? 64'd1 : 64'(W + 2));
    check({tag, " result packing R1"}, resultO, {r, q});
    check({tag, " overflow flag"}, 64'(ovfO), 64'(ov));
    stickyExp = stickyExp | ov;
    check({tag, " sticky R7"}, 64'(stickyOvfO), 64'(stickyExp));
    check({tag, " advance flag R7"}, 64'(advOvfO), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R9 watchdog act=timeout exp=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [2*W-1:0] held;
    void'($urandom(32'd4711));
    rstN = 1'b0; startI = 1'b0; opI = 8'h00; dividendI = '0; divisorI = '0;
    repeat (3) @(negedge clk);
    check("reset busy R11", 64'(busyO), 64'd0);
    check("reset done R11", 64'(doneO), 64'd0);
    check("reset result R11", resultO, 64'd0);
    check("reset flags R11", {61'd0, ovfO, stickyOvfO, advOvfO}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // directed cases; each starts on the same falling edge the previous done is seen
    runOp(1'b0, 32'd100, 32'd7, "R2 u100/7");
    runOp(1'b1, -32'sd100, 32'd7, "R3 s-100/7");
    runOp(1'b1, 32'd100, -32'sd7, "R3 s100/-7");
    runOp(1'b1, -32'sd100, -32'sd7, "R3 s-100/-7");
    runOp(1'b0, 32'hFFFF_FFFF, 32'd1, "R2 umax/1");
    runOp(1'b0, 32'd5, 32'd9, "R2 small/large");
    runOp(1'b1, 32'h8000_0000, 32'd1, "R3 mostneg/1");
    runOp(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, "R2 u 0x8 / max");
    // saturating case issued in the cycle the previous done is high
    runOp(1'b1, 32'd5, 32'd0, "R4 s5/0");
    runOp(1'b1, -32'sd5, 32'd0, "R4 s-5/0");
    runOp(1'b1, 32'd0, 32'd0, "R4 s0/0");
    runOp(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R5 mostneg/-1");
    runOp(1'b0, 32'd7, 32'd0, "R6 u7/0");
    runOp(1'b1, 32'd77, 32'd10, "R3 after overflow");

    // R8: unknown operation code leaves no trace
    held = resultO;
    opI = 8'h22; dividendI = 32'd9; divisorI = 32'd0; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    check("bad opcode busy R8", 64'(busyO), 64'd0);
    check("bad opcode done R8", 64'(doneO), 64'd0);
    repeat (3) @(negedge clk);
    check("bad opcode result R8", resultO, held);
    check("bad opcode ovf R8", 64'(ovfO), 64'd0);

    // R10: a start during the busy period is ignored
    opI = 8'h21; dividendI = 32'd1000; divisorI = 32'd3; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    repeat (4) @(negedge clk);
    opI = 8'h20; dividendI = 32'd7; divisorI = 32'd0; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    check("start while busy gives no done R10", 64'(doneO), 64'd0);
    begin
      int cyc = 6;
      while (!doneO && cyc < 100) begin
        @(negedge clk);
        cyc++;
      end
      check("busy-start latency R10", 64'(cyc), 64'(W + 2));
    end
    check("busy-start result R10", resultO, {32'd1, 32'd333});
    check("busy-start ovf R10", 64'(ovfO), 64'd0);
    @(negedge clk);
    check("no extra done R10", 64'(doneO), 64'd0);
    check("done is a pulse R1", 64'(busyO), 64'd0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      bit sgn;
      logic [31:0] a, b;
      sgn = 1'($urandom % 2);
      a = $urandom;
      b = $urandom >> ($urandom % 32);
      if (($urandom % 16) == 0) b = 32'd0;
      if (($urandom % 32) == 0) begin a = 32'h8000_0000; b = 32'hFFFF_FFFF; end
      runOp(sgn, a, b, sgn ? "R3 random signed" : "R2 random unsigned");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule